// File: doc/BRIEF.md
# Stacked-Source Multilevel Phase-Disposition PWM Generator

This block produces the gate pattern for a single-phase staircase inverter. The inverter stacks DC sources in series through a set of tap switches and then feeds an H-bridge that sets the output polarity. Internally the block builds a folded sine reference from a quarter-wave table and a triangular carrier from a counter. The magnitude of the reference is scaled to the active level count and compared against a stack of in-phase carriers, one carrier per level band. The number of carriers the reference exceeds is the instantaneous level, so the output alternates at carrier rate between two neighbouring levels.

A mode input chooses between equal sources (five level bands, eleven output levels) and a 1:2:2:2:2 weighted stack (nine bands, nineteen levels). The mode is taken only at the start of each fundamental period. A sequencer walks through five named states. `ST_LOAD` holds everything off for one cycle after reset and latches the mode, then goes to `ST_POS_RISE`. At the end of each quarter the sequencer steps `ST_POS_RISE` → `ST_POS_FALL` → `ST_NEG_RISE` → `ST_NEG_FALL`, and from `ST_NEG_FALL` back to `ST_POS_RISE`, latching the mode again on that last step. A registered output stage checks the exclusive switch groups and forces every gate off when a group is violated.

The defaults give 128 clocks per carrier period (`TRI_LOG2` = 6) and 80 clocks per reference sample. With 64 samples per fundamental, that is 40 carrier periods per fundamental.

Top module: `pdpwm_stack_gen`

## Requirements
- R1: While reset is held, and for the first cycle after it is released, `tap_o`, `hb_o`, `level_o` and `ilk_o` are all zero.
- R2: The counters start at index j = 0 in the cycle after `ST_LOAD`. Outputs are registered, so they lag the counters by one clock. The carrier is c = 16·t for t = j mod 128 below 64, and c = 16·(127−t) otherwise. The sample index is s = (j / 80) mod 64, the quarter is q = s / 16 and the position is p = s mod 16. The table index is p in quarters 0 and 2 and 16−p in quarters 1 and 3. The magnitude is round(1023·sin(π·index/32)).
- R3: In equal-source mode (mode_i = 0) the level magnitude is the number of k in 0..4 with magnitude·5 > 1024·k + c.
- R4: In weighted mode (mode_i = 1) the level magnitude is the number of k in 0..8 with magnitude·9 > 1024·k + c.
- R5: `level_o` is negative in quarters 2 and 3 and non-negative in quarters 0 and 1. `hb_o` is 4'b1001 in the positive half and 4'b0110 in the negative half, and it changes only at half-period boundaries.
- R6: In equal-source mode, level magnitude m ≥ 1 drives only `tap_o` bit m−1. Magnitude 0 drives no tap bit.
- R7: In weighted mode, a non-zero magnitude m sets bit 6 when m is odd and bit 7 when m is even. It also sets bit 5 when m/2 = 0, or bit m/2−1 otherwise. Magnitude 0 drives no tap bit.
- R8: At most one of tap bits 0..3 is on, at most one of bits 3..5 is on, and bits 6 and 7 are never on together. If a decoded pattern breaks any of these rules, the output stage drives all gates low and raises `ilk_o`. With correct decoding `ilk_o` stays low.
- R9: `mode_i` is sampled only in `ST_LOAD` and when `ST_NEG_FALL` ends. A change in the middle of a fundamental has no effect until the next fundamental begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| mode_i | input | 1 | 0 = equal sources, 1 = 1:2:2:2:2 weighted sources |
| tap_o | output | 8 | Source-stack switch gates (bits 0..5 taps, 6 unit include, 7 unit bypass) |
| hb_o | output | 4 | H-bridge gates |
| level_o | output | 5 | Signed output level currently selected |
| ilk_o | output | 1 | Exclusive-group violation, gates forced off |

## Verification
The bench compares every output cycle against a model built from the sine function and the carrier formula. This exposes an off-by-one carrier band or fold index, which would put the level one step off next to the band edges and at the quarter peaks. The mode input is toggled both near and far from fundamental boundaries. A design that applied the mode immediately would switch between five and nine bands in the middle of a period, and the level checks would catch the change. The weighted tap encoding is checked for both parities, so swapping the unit include and bypass switches, or using the wrong stack tap for m/2 = 0, shows up as a tap mismatch. A second reset in the middle of a run checks that the sequencer goes back through its load state with every gate off.

// File: rtl/pdpwm_pkg.sv
package pdpwm_pkg;

    localparam int AMP_W      = 10;
    localparam int QTR_LOG2   = 4;
    localparam int SYM_STEPS  = 5;
    localparam int ASYM_STEPS = 9;
    localparam int MAG_W      = 4;
    localparam int TAP_W      = 8;
    localparam int HB_W       = 4;

    localparam int STACK_NONE = 5;
    localparam int UNIT_IN    = 6;
    localparam int UNIT_BYP   = 7;

    localparam logic [HB_W-1:0] HB_POS = 4'b1001;
    localparam logic [HB_W-1:0] HB_NEG = 4'b0110;

    typedef enum logic [2:0] {
        ST_LOAD,
        ST_POS_RISE,
        ST_POS_FALL,
        ST_NEG_RISE,
        ST_NEG_FALL
    } phase_e;

    function automatic logic [AMP_W-1:0] quarter_sine(input logic [QTR_LOG2:0] idx);
        logic [AMP_W-1:0] v;
        case (idx)
            5'd0:    v = 10'd0;
            5'd1:    v = 10'd100;
            5'd2:    v = 10'd200;
            5'd3:    v = 10'd297;
            5'd4:    v = 10'd391;
            5'd5:    v = 10'd482;
            5'd6:    v = 10'd568;
            5'd7:    v = 10'd649;
            5'd8:    v = 10'd723;
            5'd9:    v = 10'd791;
            5'd10:   v = 10'd851;
            5'd11:   v = 10'd902;
            5'd12:   v = 10'd945;
            5'd13:   v = 10'd979;
            5'd14:   v = 10'd1003;
            5'd15:   v = 10'd1018;
            default: v = 10'd1023;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/pdpwm_seq.sv
module pdpwm_seq
    import pdpwm_pkg::*;
#(
    parameter int TRI_LOG2   = 6,
    parameter int SAMPLE_DIV = 80
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                mode_i,
    output logic [AMP_W-1:0]    carrier_o,
    output logic [QTR_LOG2:0]   lut_idx_o,
    output logic                neg_o,
    output logic                run_o,
    output logic                mode_o
);

    localparam int DIV_W = $clog2(SAMPLE_DIV);
    localparam int SHIFT = AMP_W - TRI_LOG2;

    phase_e                 phase_q, phase_d;
    logic [TRI_LOG2:0]      tri_q;
    logic [DIV_W-1:0]       div_q;
    logic [QTR_LOG2-1:0]    pos_q;
    logic                   mode_q;
    logic                   sample_end, quarter_end, falling;
    logic [TRI_LOG2-1:0]    slope;

    assign sample_end  = (div_q == DIV_W'(SAMPLE_DIV - 1));
    assign quarter_end = sample_end && (pos_q == '1);

    // next state
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            ST_LOAD:     phase_d = ST_POS_RISE;
            ST_POS_RISE: if (quarter_end) phase_d = ST_POS_FALL;
            ST_POS_FALL: if (quarter_end) phase_d = ST_NEG_RISE;
            ST_NEG_RISE: if (quarter_end) phase_d = ST_NEG_FALL;
            ST_NEG_FALL: if (quarter_end) phase_d = ST_POS_RISE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) phase_q <= ST_LOAD;
        else         phase_q <= phase_d;
    end

    // counters and mode latch
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            tri_q  <= '0;
            div_q  <= '0;
            pos_q  <= '0;
            mode_q <= 1'b0;
        end else if (phase_q == ST_LOAD) begin
            mode_q <= mode_i;
        end else begin
            tri_q <= tri_q + 1'b1;
            if (sample_end) begin
                div_q <= '0;
                pos_q <= pos_q + 1'b1;
            end else begin
                div_q <= div_q + 1'b1;
            end
            if (phase_q == ST_NEG_FALL && quarter_end) mode_q <= mode_i;
        end
    end

    // outputs
    always_comb begin
        run_o   = (phase_q != ST_LOAD);
        neg_o   = (phase_q == ST_NEG_RISE) || (phase_q == ST_NEG_FALL);
        falling = (phase_q == ST_POS_FALL) || (phase_q == ST_NEG_FALL);
        lut_idx_o = falling ? ((QTR_LOG2+1)'(1 << QTR_LOG2) - {1'b0, pos_q})
                            : {1'b0, pos_q};
        slope     = tri_q[TRI_LOG2] ? ~tri_q[TRI_LOG2-1:0] : tri_q[TRI_LOG2-1:0];
        carrier_o = AMP_W'(slope) << SHIFT;
        mode_o    = mode_q;
    end

endmodule

// File: rtl/pdpwm_level.sv
module pdpwm_level
    import pdpwm_pkg::*;
(
    input  logic [AMP_W-1:0]   carrier_i,
    input  logic [QTR_LOG2:0]  lut_idx_i,
    input  logic               mode_i,
    input  logic               run_i,
    output logic [MAG_W-1:0]   mag_o
);

    localparam int SCL_W = AMP_W + MAG_W;

    logic [AMP_W-1:0]      ref_mag;
    logic [MAG_W-1:0]      steps;
    logic [SCL_W-1:0]      scaled;
    logic [ASYM_STEPS-1:0] hits;

    assign ref_mag = quarter_sine(lut_idx_i);
    assign steps   = mode_i ? MAG_W'(ASYM_STEPS) : MAG_W'(SYM_STEPS);
    assign scaled  = SCL_W'(ref_mag) * SCL_W'(steps);

    // phase-disposition carrier stack: band k spans k*2^AMP_W upward
    for (genvar k = 0; k < ASYM_STEPS; k++) begin : g_band
        assign hits[k] = run_i && (MAG_W'(k) < steps) &&
                         (scaled > ((SCL_W'(k) << AMP_W) + SCL_W'(carrier_i)));
    end

    assign mag_o = MAG_W'($countones(hits));

endmodule

// File: rtl/pdpwm_gatemap.sv
module pdpwm_gatemap
    import pdpwm_pkg::*;
(
    input  logic [MAG_W-1:0]  mag_i,
    input  logic              mode_i,
    input  logic              neg_i,
    input  logic              run_i,
    output logic [TAP_W-1:0]  tap_o,
    output logic [HB_W-1:0]   hb_o
);

    logic [MAG_W-1:0] pairs;

    assign pairs = mag_i >> 1;

    always_comb begin
        tap_o = '0;
        hb_o  = run_i ? (neg_i ? HB_NEG : HB_POS) : '0;
        if (run_i && mag_i != '0) begin
            if (!mode_i) begin
                for (int i = 0; i < SYM_STEPS; i++)
                    if (mag_i == MAG_W'(i + 1)) tap_o[i] = 1'b1;
            end else begin
                if (mag_i[0]) tap_o[UNIT_IN]  = 1'b1;
                else          tap_o[UNIT_BYP] = 1'b1;
                if (pairs == '0) tap_o[STACK_NONE] = 1'b1;
                for (int i = 0; i < 4; i++)
                    if (pairs == MAG_W'(i + 1)) tap_o[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pdpwm_stack_gen.sv
module pdpwm_stack_gen
    import pdpwm_pkg::*;
#(
    parameter int TRI_LOG2   = 6,
    parameter int SAMPLE_DIV = 80
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    mode_i,
    output logic [TAP_W-1:0]        tap_o,
    output logic [HB_W-1:0]         hb_o,
    output logic signed [MAG_W:0]   level_o,
    output logic                    ilk_o
);

    logic [AMP_W-1:0]      carrier;
    logic [QTR_LOG2:0]     lut_idx;
    logic                  neg, run, mode_act;
    logic [MAG_W-1:0]      mag;
    logic [TAP_W-1:0]      tap_d;
    logic [HB_W-1:0]       hb_d;
    logic signed [MAG_W:0] lvl_abs, lvl_d;
    logic                  viol;

    pdpwm_seq #(.TRI_LOG2(TRI_LOG2), .SAMPLE_DIV(SAMPLE_DIV)) i_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .mode_i    (mode_i),
        .carrier_o (carrier),
        .lut_idx_o (lut_idx),
        .neg_o     (neg),
        .run_o     (run),
        .mode_o    (mode_act)
    );

    pdpwm_level i_level (
        .carrier_i (carrier),
        .lut_idx_i (lut_idx),
        .mode_i    (mode_act),
        .run_i     (run),
        .mag_o     (mag)
    );

    pdpwm_gatemap i_map (
        .mag_i  (mag),
        .mode_i (mode_act),
        .neg_i  (neg),
        .run_i  (run),
        .tap_o  (tap_d),
        .hb_o   (hb_d)
    );

    assign lvl_abs = $signed({1'b0, mag});
    assign lvl_d   = neg ? -lvl_abs : lvl_abs;
    assign viol    = ($countones(tap_d[3:0]) > 1) ||
                     ($countones(tap_d[5:3]) > 1) ||
                     (tap_d[UNIT_IN] && tap_d[UNIT_BYP]);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            tap_o   <= '0;
            hb_o    <= '0;
            level_o <= '0;
            ilk_o   <= 1'b0;
        end else if (viol) begin
            tap_o   <= '0;
            hb_o    <= '0;
            level_o <= '0;
            ilk_o   <= 1'b1;
        end else begin
            tap_o   <= tap_d;
            hb_o    <= hb_d;
            level_o <= lvl_d;
            ilk_o   <= 1'b0;
        end
    end

endmodule

// File: rtl/pdpwm_stack_chk.sv
module pdpwm_stack_chk (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [7:0]        tap_o,
    input logic [3:0]        hb_o,
    input logic signed [4:0] level_o,
    input logic              ilk_o
);

    a_r1_start_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |=> (tap_o == 8'h00 && hb_o == 4'h0));

    a_r5_sign_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (level_o > 0) |-> (hb_o == 4'b1001));

    a_r5_sign_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (level_o < 0) |-> (hb_o == 4'b0110));

    a_r6_one_tap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (level_o != 0) |-> ($countones(tap_o[5:0]) == 1));

    a_r6_zero_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (level_o == 0) |-> (tap_o == 8'h00));

    a_r7_unit_odd: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tap_o[6] |-> level_o[0]);

    a_r7_unit_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tap_o[7] |-> !level_o[0]);

    a_r8_group_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(tap_o[3:0]) <= 1);

    a_r8_group_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(tap_o[5:3]) <= 1);

    a_r8_unit_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(tap_o[6] && tap_o[7]));

    a_r8_trip_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ilk_o |-> (tap_o == 8'h00 && hb_o == 4'h0));

endmodule

bind pdpwm_stack_gen pdpwm_stack_chk i_pdpwm_stack_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tap_o   (tap_o),
    .hb_o    (hb_o),
    .level_o (level_o),
    .ilk_o   (ilk_o)
);

// File: tb/test_pdpwm_stack_gen.sv
`timescale 1ns/1ps
module test_pdpwm_stack_gen;

    localparam int SD    = 80;
    localparam int FUND  = 64 * SD;
    localparam int LIMIT = 200000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode = 1'b0;
    logic [7:0]        tap;
    logic [3:0]        hb;
    logic signed [4:0] lvl;
    logic              ilk;

    int total = 0;
    int bad   = 0;
    int kcnt  = 0;
    int mode_hist [0:15];
    bit checking = 1'b0;

    always #2.5 clk = ~clk;

    pdpwm_stack_gen i_pdpwm_stack_gen (
        .clk_i (clk), .rst_ni (rst_n), .mode_i (mode),
        .tap_o (tap), .hb_o (hb), .level_o (lvl), .ilk_o (ilk)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_mag(input int idx);
        return $rtoi(1023.0 * $sin(3.14159265358979 * idx / 32.0) + 0.5);
    endfunction

    function automatic int exp_level(input int j, input int md);
        int t, c, s, q, p, idx, sc, lv;
        t   = j % 128;
        c   = (t < 64) ? t * 16 : (127 - t) * 16;
        s   = (j / SD) % 64;
        q   = s / 16;
        p   = s % 16;
        idx = (q % 2 == 1) ? 16 - p : p;
        sc  = ref_mag(idx) * (md ? 9 : 5);
        lv  = sc / 1024 + (((sc % 1024) > c) ? 1 : 0);
        return (q >= 2) ? -lv : lv;
    endfunction

    function automatic int exp_tap(input int lv, input int md);
        int m;
        m = (lv < 0) ? -lv : lv;
        if (m == 0) return 0;
        if (md == 0) return 1 << (m - 1);
        return ((m % 2 == 1) ? (1 << 6) : (1 << 7)) |
               ((m / 2 == 0) ? (1 << 5) : (1 << (m / 2 - 1)));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) kcnt <= 0;
        else begin
            if (kcnt % FUND == 0 && kcnt / FUND < 16) mode_hist[kcnt / FUND] <= int'(mode);
            kcnt <= kcnt + 1;
        end
    end

    always @(negedge clk) begin
        if (checking && rst_n) begin
            int j, f, md, el, et, eh;
            j = kcnt - 2;
            if (j < 0) begin
                check(tap == 0 && hb == 0 && lvl == 0 && ilk == 0, "R1 start", int'(tap), 0);
            end else begin
                f  = j / FUND;
                md = mode_hist[f];
                el = exp_level(j, md);
                et = exp_tap(el, md);
                eh = (((j / SD) % 64) / 16 >= 2) ? 6 : 9;
                if (int'(mode) != md)       check(int'(lvl) == el, "R9 mode held", int'(lvl), el);
                else if (j % SD == 0)        check(int'(lvl) == el, "R2 sample edge", int'(lvl), el);
                else if (md == 0)            check(int'(lvl) == el, "R3 equal level", int'(lvl), el);
                else                         check(int'(lvl) == el, "R4 weighted level", int'(lvl), el);
                if (md == 0) check(int'(tap) == et, "R6 equal taps", int'(tap), et);
                else         check(int'(tap) == et, "R7 weighted taps", int'(tap), et);
                check(int'(hb) == eh, "R5 bridge", int'(hb), eh);
                check(ilk == 1'b0, "R8 interlock", int'(ilk), 0);
            end
        end
    end

    task automatic run_cycles(input int n, input int flip_odds);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (flip_odds > 0 && ($urandom % flip_odds) == 0) mode = ~mode;
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 16; i++) mode_hist[i] = 0;
        repeat (4) @(negedge clk);
        check(tap == 0 && hb == 0 && lvl == 0 && ilk == 0, "R1 in reset", int'(tap), 0);
        checking = 1'b1;
        rst_n = 1'b1;
        // fundamental 0 equal-source, switch to weighted shortly before boundary
        run_cycles(FUND - 20, 0);
        mode = 1'b1;
        // fundamental 1 weighted; mid-period change must not apply (R9)
        run_cycles(20 + FUND / 3, 0);
        mode = 1'b0;
        run_cycles(FUND / 3, 0);
        mode = 1'b1;
        run_cycles(FUND - 2 * (FUND / 3) - 1, 0);
        mode = 1'b0;   // changed one cycle before the boundary
        run_cycles(FUND + 5, 0);
        // random toggling over several fundamentals
        run_cycles(4 * FUND, 1500);
        // mid-run reset
        @(negedge clk);
        checking = 1'b0;
        rst_n = 1'b0;
        mode = 1'b1;
        repeat (3) @(negedge clk);
        check(tap == 0 && hb == 0 && lvl == 0 && ilk == 0, "R1 re-reset", int'(tap), 0);
        checking = 1'b1;
        rst_n = 1'b1;
        run_cycles(2 * FUND, 900);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(LIMIT * 5.0);
        bad++;
        $display("FAIL watchdog R1 act=%0d exp=%0d", kcnt, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule